// File: doc/BRIEF.md
# UART Line Transceiver with Data Inversion and Bus-Collision Check

This block pairs an asynchronous serial transmitter with a receiver and adds three line-level features. A data-inversion control flips every bit of a byte as it enters the transmit holding register and again as it leaves the receive register. The start, parity and stop framing is not touched by this control. A separate pin-reversal control inverts every level on the serial output and the serial input, framing bits included. A collision checker compares the driven serial output with the observed serial input once per bit while a frame is being sent. It raises a one-cycle pulse and a sticky request when the two levels differ.

Software writes one byte at a time through a write strobe and reads received bytes through a read strobe. Bit timing comes from an external enable tick at sixteen ticks per bit. Three interrupt requests are provided: holding register emptied, byte received, and collision. Each request stays set until its own clearing access.

Top module: `uart_line_xcvr`

## Requirements
- R1: After reset, `txd` is at the mark level (1 with `cfg_pin_rev`=0), and `irq_tx_empty`, `irq_rx_done`, `irq_coll` and `coll_pulse` are all 0.
- R2: A transmitted frame on the logical line is one start bit at 0, then eight data bits with bit 0 first, then an even-parity bit (the XOR of the eight data bits) only when `cfg_par_en`=1, then one stop bit at 1. Each bit lasts 16 `baud_tick` pulses. The line rests at 1 between frames.
- R3: With `cfg_data_inv`=1, the written byte is complemented when it is stored, so the complement goes on the line and the parity covers the complemented bits. The received byte is complemented when it is presented on `rd_data`. Start, parity position and stop levels do not change.
- R4: With `cfg_pin_rev`=1, `txd` is the logical line level inverted for every bit, including idle, start, parity and stop. `rxd` is inverted before it is interpreted. A looped-back frame is still received correctly.
- R5: The receiver detects a start edge, samples each bit at its middle, and on the stop bit updates `rd_data` and sets `irq_rx_done`. `rd_en` clears `irq_rx_done`. If a byte completes in the same cycle as `rd_en`, the request stays set.
- R6: With parity enabled, `rx_err_par` is 1 for a received byte whose parity bit does not give even parity over its data bits, and 0 otherwise.
- R7: `rx_err_frame` is 1 for a received byte whose stop bit is sampled at 0 (logical level), and 0 otherwise.
- R8: `wr_en` is accepted only while the holding register is empty. A write while it is full is ignored and its byte is never sent. `irq_tx_empty` sets when the held byte moves into the shifter and clears on an accepted write.
- R9: With `cfg_coll_en`=1, each mid-bit compare during a frame that finds the `txd` and `rxd` pin levels differing produces a one-cycle `coll_pulse`, followed by `irq_coll`=1. `irq_coll` holds until `coll_clr`. A detection in the same cycle as `coll_clr` leaves it set.
- R10: No `coll_pulse` is produced while no frame is being sent, while `cfg_coll_en`=0, or while the pin levels agree, including when both are reversed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | Oversampling enable, 16 per bit |
| cfg_par_en | input | 1 | Append/check even parity |
| cfg_data_inv | input | 1 | Complement data byte on write and read |
| cfg_pin_rev | input | 1 | Invert all levels on txd and rxd |
| cfg_coll_en | input | 1 | Enable collision compare |
| wr_en | input | 1 | Write strobe for transmit byte |
| wr_data | input | 8 | Byte to transmit |
| rd_en | input | 1 | Read access, clears irq_rx_done |
| rd_data | output | 8 | Last received byte |
| rx_err_frame | output | 1 | Stop bit of last byte was 0 |
| rx_err_par | output | 1 | Parity mismatch on last byte |
| coll_clr | input | 1 | Clears irq_coll |
| txd | output | 1 | Serial output pin |
| rxd | input | 1 | Serial input pin |
| irq_tx_empty | output | 1 | Holding register emptied request |
| irq_rx_done | output | 1 | Byte received request |
| irq_coll | output | 1 | Sticky collision request |
| coll_pulse | output | 1 | One-cycle collision detection pulse |

## Verification
Two pairs of events can land on the same edge: a fresh collision detection and the software clear of the collision request, and a byte completing at the receiver and the read access that clears its request. The bench holds `coll_clr` high through a frame whose looped-back input is inverted. On the cycle after the first pulse it expects the request to read 1, and on the cycle after that it expects 0. The same approach is used for the receive request, with `rd_en` held high while a byte arrives: the request must be seen set for one cycle and then cleared.

// File: rtl/uart_lx_pkg.sv
package uart_lx_pkg;
   typedef enum logic [1:0] {
      RX_IDLE  = 2'd0,
      RX_START = 2'd1,
      RX_BITS  = 2'd2
   } rx_state_t;
endpackage

// File: rtl/uart_lx_tx.sv
module uart_lx_tx #(
   parameter int DATA_W         = 8,
   parameter int OVERSAMPLE     = 16,
   parameter int PARITY_SUPPORT = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              baud_tick,
   input  logic              par_en,
   input  logic              data_inv,
   input  logic              pin_rev,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic              txd,
   output logic              busy,
   output logic              mid_strobe,
   output logic              irq_empty
);
   localparam int CNT_W = $clog2(OVERSAMPLE);
   localparam int IDX_W = $clog2(DATA_W + 3);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OVERSAMPLE - 1);
   localparam logic [CNT_W-1:0] CNT_MID  = CNT_W'(OVERSAMPLE / 2 - 1);
   localparam logic [IDX_W-1:0] IDX_DLAST = IDX_W'(DATA_W);
   localparam logic [IDX_W-1:0] IDX_PAR   = IDX_W'(DATA_W + 1);
   localparam logic [IDX_W-1:0] IDX_STOP2 = IDX_W'(DATA_W + 2);

   logic [DATA_W-1:0] hold_q;
   logic              hold_full_q;
   logic [DATA_W-1:0] shift_q;
   logic              par_bit_q;
   logic              frame_par_q;
   logic [IDX_W-1:0]  idx_q;
   logic [CNT_W-1:0]  cnt_q;
   logic              busy_q;
   logic              empty_q;
   logic              par_calc;
   logic              accept;
   logic              load;
   logic              line_lvl;
   logic [IDX_W-1:0]  idx_last;

   // parity generator variant chosen at elaboration
   generate
      if (PARITY_SUPPORT != 0) begin : g_par
         assign par_calc = ^hold_q;
      end else begin : g_nopar
         assign par_calc = 1'b0;
      end
   endgenerate

   assign accept   = wr_en && !hold_full_q;
   assign load     = !busy_q && hold_full_q;
   assign idx_last = frame_par_q ? IDX_STOP2 : IDX_PAR;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q      <= '0;
         hold_full_q <= 1'b0;
         empty_q     <= 1'b0;
      end else begin
         if (accept) begin
            hold_q      <= wr_data ^ {DATA_W{data_inv}};
            hold_full_q <= 1'b1;
            empty_q     <= 1'b0;
         end else if (load) begin
            hold_full_q <= 1'b0;
            empty_q     <= 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shift_q     <= '0;
         par_bit_q   <= 1'b0;
         frame_par_q <= 1'b0;
         idx_q       <= '0;
         cnt_q       <= '0;
         busy_q      <= 1'b0;
      end else if (load) begin
         shift_q     <= hold_q;
         par_bit_q   <= par_calc;
         frame_par_q <= par_en && (PARITY_SUPPORT != 0);
         idx_q       <= '0;
         cnt_q       <= '0;
         busy_q      <= 1'b1;
      end else if (busy_q && baud_tick) begin
         if (cnt_q == CNT_LAST) begin
            cnt_q <= '0;
            if (idx_q == idx_last) begin
               busy_q <= 1'b0;
            end else begin
               idx_q <= idx_q + 1'b1;
            end
            if (idx_q != '0 && idx_q <= IDX_DLAST) begin
               shift_q <= {1'b0, shift_q[DATA_W-1:1]};
            end
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   always_comb begin
      if (!busy_q) begin
         line_lvl = 1'b1;
      end else if (idx_q == '0) begin
         line_lvl = 1'b0;
      end else if (idx_q <= IDX_DLAST) begin
         line_lvl = shift_q[0];
      end else if (idx_q == IDX_PAR && frame_par_q) begin
         line_lvl = par_bit_q;
      end else begin
         line_lvl = 1'b1;
      end
   end

   assign txd        = line_lvl ^ pin_rev;
   assign busy       = busy_q;
   assign mid_strobe = busy_q && baud_tick && (cnt_q == CNT_MID);
   assign irq_empty  = empty_q;
endmodule

// File: rtl/uart_lx_rx.sv
module uart_lx_rx
   import uart_lx_pkg::*;
#(
   parameter int DATA_W         = 8,
   parameter int OVERSAMPLE     = 16,
   parameter int SYNC_STAGES    = 2,
   parameter int PARITY_SUPPORT = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              baud_tick,
   input  logic              par_en,
   input  logic              data_inv,
   input  logic              pin_rev,
   input  logic              rxd,
   input  logic              rd_en,
   output logic [DATA_W-1:0] rd_data,
   output logic              irq_done,
   output logic              err_frame,
   output logic              err_par,
   output logic              rxd_pin_sync
);
   localparam int CNT_W = $clog2(OVERSAMPLE);
   localparam int IDX_W = $clog2(DATA_W + 3);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OVERSAMPLE - 1);
   localparam logic [CNT_W-1:0] CNT_MID  = CNT_W'(OVERSAMPLE / 2 - 1);
   localparam logic [IDX_W-1:0] IDX_DATA = IDX_W'(DATA_W);

   logic [SYNC_STAGES-1:0] sync_q;
   rx_state_t              state_q;
   logic [CNT_W-1:0]       cnt_q;
   logic [IDX_W-1:0]       idx_q;
   logic [DATA_W-1:0]      shift_q;
   logic [DATA_W-1:0]      rbuf_q;
   logic                   pbit_q;
   logic                   frame_par_q;
   logic                   done_q;
   logic                   ferr_q;
   logic                   perr_q;
   logic                   done_set;
   logic                   line_lvl;

   // input synchronizer chain, depth by parameter
   generate
      for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) sync_q[0] <= 1'b1;
               else        sync_q[0] <= rxd;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) sync_q[s] <= 1'b1;
               else        sync_q[s] <= sync_q[s-1];
            end
         end
      end
   endgenerate

   assign rxd_pin_sync = sync_q[SYNC_STAGES-1];
   assign line_lvl     = rxd_pin_sync ^ pin_rev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= RX_IDLE;
         cnt_q       <= '0;
         idx_q       <= '0;
         shift_q     <= '0;
         rbuf_q      <= '0;
         pbit_q      <= 1'b0;
         frame_par_q <= 1'b0;
         ferr_q      <= 1'b0;
         perr_q      <= 1'b0;
         done_set    <= 1'b0;
      end else begin
         done_set <= 1'b0;
         if (baud_tick) begin
            unique case (state_q)
               RX_IDLE: begin
                  if (!line_lvl) begin
                     state_q     <= RX_START;
                     cnt_q       <= '0;
                     frame_par_q <= par_en && (PARITY_SUPPORT != 0);
                  end
               end
               RX_START: begin
                  if (cnt_q == CNT_MID) begin
                     cnt_q   <= '0;
                     idx_q   <= '0;
                     state_q <= line_lvl ? RX_IDLE : RX_BITS;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
               RX_BITS: begin
                  if (cnt_q == CNT_LAST) begin
                     cnt_q <= '0;
                     if (idx_q < IDX_DATA) begin
                        shift_q <= {line_lvl, shift_q[DATA_W-1:1]};
                        idx_q   <= idx_q + 1'b1;
                     end else if (idx_q == IDX_DATA && frame_par_q) begin
                        pbit_q <= line_lvl;
                        idx_q  <= idx_q + 1'b1;
                     end else begin
                        rbuf_q   <= shift_q;
                        ferr_q   <= !line_lvl;
                        perr_q   <= frame_par_q && ((^shift_q) ^ pbit_q);
                        done_set <= 1'b1;
                        state_q  <= RX_IDLE;
                     end
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
               default: state_q <= RX_IDLE;
            endcase
         end
      end
   end

   // request: a new byte outranks the clearing read
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        done_q <= 1'b0;
      else if (done_set) done_q <= 1'b1;
      else if (rd_en)    done_q <= 1'b0;
   end

   assign rd_data   = rbuf_q ^ {DATA_W{data_inv}};
   assign irq_done  = done_q;
   assign err_frame = ferr_q;
   assign err_par   = perr_q;
endmodule

// File: rtl/uart_lx_coll.sv
module uart_lx_coll (
   input  logic clk,
   input  logic rst_n,
   input  logic enable,
   input  logic strobe,
   input  logic txd_pin,
   input  logic rxd_pin,
   input  logic clr,
   output logic pulse,
   output logic flag
);
   logic pulse_q;
   logic flag_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pulse_q <= 1'b0;
      else        pulse_q <= strobe && enable && (txd_pin != rxd_pin);
   end

   // detection outranks the software clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       flag_q <= 1'b0;
      else if (pulse_q) flag_q <= 1'b1;
      else if (clr)     flag_q <= 1'b0;
   end

   assign pulse = pulse_q;
   assign flag  = flag_q;
endmodule

// File: rtl/uart_line_xcvr.sv
module uart_line_xcvr #(
   parameter int DATA_W         = 8,
   parameter int OVERSAMPLE     = 16,
   parameter int SYNC_STAGES    = 2,
   parameter int PARITY_SUPPORT = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              baud_tick,
   input  logic              cfg_par_en,
   input  logic              cfg_data_inv,
   input  logic              cfg_pin_rev,
   input  logic              cfg_coll_en,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_en,
   output logic [DATA_W-1:0] rd_data,
   output logic              rx_err_frame,
   output logic              rx_err_par,
   input  logic              coll_clr,
   output logic              txd,
   input  logic              rxd,
   output logic              irq_tx_empty,
   output logic              irq_rx_done,
   output logic              irq_coll,
   output logic              coll_pulse
);
   initial begin : cfg_check
      if (DATA_W < 5 || DATA_W > 9)
         $fatal(1, "uart_line_xcvr: DATA_W must be 5..9");
      if (OVERSAMPLE < 4 || (OVERSAMPLE % 2) != 0 || (OVERSAMPLE & (OVERSAMPLE - 1)) != 0)
         $fatal(1, "uart_line_xcvr: OVERSAMPLE must be an even power of two >= 4");
      if (SYNC_STAGES < 1 || SYNC_STAGES > 4)
         $fatal(1, "uart_line_xcvr: SYNC_STAGES must be 1..4");
   end

   logic tx_busy_w;
   logic mid_strobe_w;
   logic rxd_sync_w;
   logic txd_w;

   uart_lx_tx #(
      .DATA_W(DATA_W), .OVERSAMPLE(OVERSAMPLE), .PARITY_SUPPORT(PARITY_SUPPORT)
   ) u_tx (
      .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick),
      .par_en(cfg_par_en), .data_inv(cfg_data_inv), .pin_rev(cfg_pin_rev),
      .wr_en(wr_en), .wr_data(wr_data),
      .txd(txd_w), .busy(tx_busy_w), .mid_strobe(mid_strobe_w),
      .irq_empty(irq_tx_empty)
   );

   uart_lx_rx #(
      .DATA_W(DATA_W), .OVERSAMPLE(OVERSAMPLE), .SYNC_STAGES(SYNC_STAGES),
      .PARITY_SUPPORT(PARITY_SUPPORT)
   ) u_rx (
      .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick),
      .par_en(cfg_par_en), .data_inv(cfg_data_inv), .pin_rev(cfg_pin_rev),
      .rxd(rxd), .rd_en(rd_en), .rd_data(rd_data), .irq_done(irq_rx_done),
      .err_frame(rx_err_frame), .err_par(rx_err_par), .rxd_pin_sync(rxd_sync_w)
   );

   uart_lx_coll u_coll (
      .clk(clk), .rst_n(rst_n), .enable(cfg_coll_en), .strobe(mid_strobe_w),
      .txd_pin(txd_w), .rxd_pin(rxd_sync_w), .clr(coll_clr),
      .pulse(coll_pulse), .flag(irq_coll)
   );

   assign txd = txd_w;
endmodule

// File: rtl/uart_lx_chk.sv
module uart_lx_chk (
   input logic clk,
   input logic rst_n,
   input logic txd,
   input logic cfg_pin_rev,
   input logic tx_busy,
   input logic coll_pulse,
   input logic irq_coll,
   input logic coll_clr,
   input logic irq_rx_done,
   input logic rd_en,
   input logic wr_en,
   input logic irq_tx_empty
);
   assert_idle_mark_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_busy |-> (txd == !cfg_pin_rev));

   assert_no_coll_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_busy |=> !coll_pulse);

   assert_pulse_sets_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
      coll_pulse |=> irq_coll);

   assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_coll && !coll_clr) |=> irq_coll);

   assert_rx_done_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_rx_done && !rd_en) |=> irq_rx_done);

   assert_tx_empty_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && irq_tx_empty) |=> !irq_tx_empty);
endmodule

bind uart_line_xcvr uart_lx_chk u_chk (
   .clk(clk), .rst_n(rst_n), .txd(txd), .cfg_pin_rev(cfg_pin_rev),
   .tx_busy(tx_busy_w), .coll_pulse(coll_pulse), .irq_coll(irq_coll),
   .coll_clr(coll_clr), .irq_rx_done(irq_rx_done), .rd_en(rd_en),
   .wr_en(wr_en), .irq_tx_empty(irq_tx_empty)
);

// File: tb/tb_uart_line_xcvr.sv
`timescale 1ns/1ps
module tb_uart_line_xcvr;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic par = 1'b0, inv = 1'b0, rev = 1'b0, cen = 1'b0;
   logic wr_en = 1'b0, rd_en = 1'b0, coll_clr = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic [7:0] rd_data;
   logic rx_err_frame, rx_err_par, txd, rxd;
   logic irq_tx_empty, irq_rx_done, irq_coll, coll_pulse;
   logic man = 1'b0, man_lvl = 1'b1, flip = 1'b0;
   int checks = 0, errors = 0, pulse_cnt = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   assign rxd = man ? man_lvl : (txd ^ flip);

   uart_line_xcvr dut (
      .clk(clk), .rst_n(rst_n), .baud_tick(1'b1),
      .cfg_par_en(par), .cfg_data_inv(inv), .cfg_pin_rev(rev), .cfg_coll_en(cen),
      .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
      .rx_err_frame(rx_err_frame), .rx_err_par(rx_err_par), .coll_clr(coll_clr),
      .txd(txd), .rxd(rxd), .irq_tx_empty(irq_tx_empty), .irq_rx_done(irq_rx_done),
      .irq_coll(irq_coll), .coll_pulse(coll_pulse)
   );

   always @(negedge clk) if (coll_pulse) pulse_cnt++;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
   endtask

   task automatic wait_rx(input int limit);
      for (int t = 0; t < limit && !irq_rx_done; t++) @(negedge clk);
   endtask

   task automatic read_clear();
      @(negedge clk) rd_en = 1'b1;
      @(negedge clk) rd_en = 1'b0;
   endtask

   // sends a byte in loopback, checks the pin waveform and the received byte
   task automatic send_check(input logic [7:0] b, input string req);
      logic [7:0]  d;
      logic [11:0] expb, got;
      int n;
      d = b ^ {8{inv}};
      n = par ? 11 : 10;
      expb = '0;
      for (int i = 0; i < 8; i++) expb[1+i] = d[i];
      if (par) begin expb[9] = ^d; expb[10] = 1'b1; end
      else expb[9] = 1'b1;
      @(negedge clk) begin wr_en = 1'b1; wr_data = b; end
      @(negedge clk) wr_en = 1'b0;
      for (int t = 0; t < 400 && txd !== rev; t++) @(negedge clk);
      repeat (7) @(negedge clk);
      got = '0;
      for (int i = 0; i < n; i++) begin
         got[i] = txd ^ rev;
         if (i < n - 1) repeat (16) @(negedge clk);
      end
      chk(got == expb, {req, " frame bits"}, int'(got), int'(expb));
      wait_rx(200);
      chk(irq_rx_done && rd_data == b && !rx_err_frame && !rx_err_par,
          {req, " R5 loopback byte"}, int'({irq_rx_done, rx_err_frame, rx_err_par, rd_data}),
          int'({3'b100, b}));
      read_clear();
      chk(!irq_rx_done, {req, " R5 read clears"}, int'(irq_rx_done), 0);
   endtask

   // drives a logical frame on rxd (bit 0 first), 16 cycles per bit
   task automatic drive_frame(input logic [11:0] bits, input int n);
      man = 1'b1;
      for (int i = 0; i < n; i++) begin
         man_lvl = bits[i] ^ rev;
         repeat (16) @(negedge clk);
      end
      man_lvl = ~rev;
   endtask

   initial begin : watchdog
      repeat (190000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog all requirements actual=timeout expected=completion");
         summary();
         $finish;
      end
   end

   initial begin : main
      int p0;
      logic [7:0] vals [8] = '{8'h00, 8'hFF, 8'h01, 8'h80, 8'hA5, 8'h5A, 8'h3C, 8'h7E};
      repeat (4) @(negedge clk);
      // R1 reset state
      chk(txd == 1'b1 && !irq_tx_empty && !irq_rx_done && !irq_coll && !coll_pulse, "R1 reset",
          int'({txd, irq_tx_empty, irq_rx_done, irq_coll, coll_pulse}), 5'b10000);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      chk(txd == 1'b1, "R1 idle mark after reset", int'(txd), 1);

      // R2 R5 R10 exhaustive byte sweep, parity on, clean loopback with compare enabled
      par = 1'b1; cen = 1'b1;
      p0 = pulse_cnt;
      for (int v = 0; v < 256; v++) send_check(8'(v), "R2 sweep");
      chk(pulse_cnt == p0, "R10 clean loopback no pulses", pulse_cnt - p0, 0);

      // R3 R4 remaining configurations
      for (int c = 0; c < 8; c++) begin
         if (c == 4) continue;
         par = c[2]; inv = c[1]; rev = c[0];
         repeat (40) @(negedge clk);
         if (irq_rx_done) read_clear();
         p0 = pulse_cnt;
         for (int k = 0; k < 8; k++) send_check(vals[k], "R3 R4 config");
         chk(pulse_cnt == p0, "R10 R4 matched pins no pulses", pulse_cnt - p0, 0);
         chk(txd == rev ^ 1'b1, "R4 idle level", int'(txd), int'(~rev));
      end

      // R8 holding register: second write accepted, third ignored
      par = 1'b0; inv = 1'b0; rev = 1'b0;
      repeat (40) @(negedge clk);
      if (irq_rx_done) read_clear();
      @(negedge clk) begin wr_en = 1'b1; wr_data = 8'h11; end
      @(negedge clk) wr_en = 1'b0;
      @(negedge clk);
      chk(irq_tx_empty, "R8 empty after move to shifter", int'(irq_tx_empty), 1);
      @(negedge clk) begin wr_en = 1'b1; wr_data = 8'h22; end
      @(negedge clk) begin wr_data = 8'h33; end
      chk(!irq_tx_empty, "R8 accepted write clears empty", int'(irq_tx_empty), 0);
      @(negedge clk) wr_en = 1'b0;
      wait_rx(400);
      chk(irq_rx_done && rd_data == 8'h11, "R8 first byte", int'(rd_data), 8'h11);
      read_clear();
      wait_rx(400);
      chk(irq_rx_done && rd_data == 8'h22, "R8 second byte", int'(rd_data), 8'h22);
      read_clear();
      repeat (400) @(negedge clk);
      chk(!irq_rx_done && irq_tx_empty, "R8 write while full ignored",
          int'({irq_rx_done, irq_tx_empty}), 2'b01);

      // R6 parity error, R3 read inversion, R7 framing error (manual rxd)
      par = 1'b1;
      drive_frame({1'b1, 1'b1, 8'hA5, 1'b0}, 11);
      wait_rx(50);
      chk(irq_rx_done && rx_err_par && !rx_err_frame && rd_data == 8'hA5, "R6 bad parity",
          int'({rx_err_par, rx_err_frame, rd_data}), int'({2'b10, 8'hA5}));
      read_clear();
      repeat (40) @(negedge clk);
      drive_frame({1'b1, 1'b0, 8'hA5, 1'b0}, 11);
      wait_rx(50);
      chk(irq_rx_done && !rx_err_par && !rx_err_frame, "R6 good parity",
          int'({rx_err_par, rx_err_frame}), 0);
      read_clear();
      inv = 1'b1;
      repeat (40) @(negedge clk);
      drive_frame({1'b1, 1'b0, 8'h3C, 1'b0}, 11);
      wait_rx(50);
      chk(irq_rx_done && rd_data == 8'hC3, "R3 read inversion", int'(rd_data), 8'hC3);
      read_clear();
      inv = 1'b0; par = 1'b0;
      repeat (40) @(negedge clk);
      drive_frame({1'b0, 8'h5A, 1'b0}, 10);
      wait_rx(50);
      chk(irq_rx_done && rx_err_frame, "R7 stop at zero", int'(rx_err_frame), 1);
      repeat (400) @(negedge clk);
      read_clear();
      drive_frame({1'b1, 8'h5A, 1'b0}, 10);
      wait_rx(50);
      chk(irq_rx_done && !rx_err_frame && rd_data == 8'h5A, "R7 good stop",
          int'({rx_err_frame, rd_data}), int'({1'b0, 8'h5A}));
      read_clear();
      man = 1'b0;
      repeat (60) @(negedge clk);
      if (irq_rx_done) read_clear();

      // R5 same cycle: byte completes while rd_en held
      begin
         bit seen;
         seen = 1'b0;
         rd_en = 1'b1;
         @(negedge clk) begin wr_en = 1'b1; wr_data = 8'h96; end
         @(negedge clk) wr_en = 1'b0;
         for (int t = 0; t < 300 && !seen; t++) begin
            @(negedge clk);
            if (irq_rx_done) seen = 1'b1;
         end
         chk(seen, "R5 completion wins over read", int'(seen), 1);
         @(negedge clk);
         chk(!irq_rx_done, "R5 held read clears next", int'(irq_rx_done), 0);
         rd_en = 1'b0;
      end
      repeat (40) @(negedge clk);

      // R9 collisions: ten mismatched bits, no parity
      flip = 1'b1;
      p0 = pulse_cnt;
      @(negedge clk) begin wr_en = 1'b1; wr_data = 8'h4B; end
      @(negedge clk) wr_en = 1'b0;
      repeat (190) @(negedge clk);
      chk(pulse_cnt - p0 == 10, "R9 one pulse per bit", pulse_cnt - p0, 10);
      chk(irq_coll, "R9 flag latched", int'(irq_coll), 1);
      repeat (20) @(negedge clk);
      chk(irq_coll, "R9 flag holds", int'(irq_coll), 1);
      @(negedge clk) coll_clr = 1'b1;
      @(negedge clk) coll_clr = 1'b0;
      chk(!irq_coll, "R9 clear", int'(irq_coll), 0);

      // R9 same cycle: clear held while detections arrive
      coll_clr = 1'b1;
      @(negedge clk) begin wr_en = 1'b1; wr_data = 8'hC6; end
      @(negedge clk) wr_en = 1'b0;
      for (int t = 0; t < 100 && !coll_pulse; t++) @(negedge clk);
      @(negedge clk);
      chk(irq_coll, "R9 detection wins over clear", int'(irq_coll), 1);
      @(negedge clk);
      chk(!irq_coll, "R9 held clear takes effect", int'(irq_coll), 0);
      repeat (190) @(negedge clk);
      coll_clr = 1'b0;
      @(negedge clk);

      // R10 compare disabled and idle mismatch
      cen = 1'b0;
      p0 = pulse_cnt;
      @(negedge clk) begin wr_en = 1'b1; wr_data = 8'hE1; end
      @(negedge clk) wr_en = 1'b0;
      repeat (200) @(negedge clk);
      cen = 1'b1;
      repeat (100) @(negedge clk);
      chk(pulse_cnt == p0 && !irq_coll, "R10 disabled or idle",
          pulse_cnt - p0, 0);
      flip = 1'b0;

      finished = 1'b1;
      summary();
      $finish;
   end
endmodule